// File: doc/BRIEF.md
# Leaf Fetch and Ray Issue Sequencer

This block sits at the front of a geometry unit and turns one leaf-node job into datapath work. A job names a thread of four rays, a base address and a mode bit. Mode 0 means the leaf holds a triangle, so the three items fetched are its vertices. Mode 1 means the leaf holds a transform, so the three items fetched are matrix rows used to move the rays into a subtree. In both modes the block sends three tagged memory requests. It collects the three responses in whatever order memory returns them. Only when all three are present does it start issuing.

Issue takes a fixed eight cycles. Each of the four rays uses two back-to-back pipeline slots, marked by a phase bit. The mode bit travels with every issue beat, so one shared arithmetic datapath can serve both intersection and transformation. A done pulse marks the final beat. The block then returns to idle and can take the next leaf.

The controller has four states. `ST_IDLE` moves to `ST_FETCH` when a leaf is accepted. `ST_FETCH` moves to `ST_WAIT` when the third request handshake completes. `ST_WAIT` moves to `ST_ISSUE` in the cycle in which the last missing response arrives. `ST_ISSUE` moves back to `ST_IDLE` after its eighth beat.

Top module: `geom_leaf_sequencer`

## Requirements
- R1: After reset, leaf_ready is 1 and fetch_req_valid, issue_valid and thread_done are all 0.
- R2: A leaf is taken on a cycle where leaf_valid and leaf_ready are both 1. From that point until the cycle after thread_done, leaf_ready stays 0, and any leaf_valid presented in that window is ignored.
- R3: Each accepted leaf produces exactly three request handshakes, with tags 0, 1 and 2 in that order. The request address is the leaf base plus tag times 16. fetch_req_kind equals the leaf mode (0 = vertex, 1 = matrix row). While fetch_req_ready is 0, the pending request stays valid and unchanged.
- R4: issue_valid stays 0 until a response has been seen for each of tags 0, 1 and 2, whatever order they arrive in.
- R5: The first issue beat appears in the cycle right after the clock edge that samples the last missing response.
- R6: Issue runs for eight consecutive cycles in the order (ray, phase) = (0,0), (0,1), (1,0), (1,1), (2,0), (2,1), (3,0), (3,1). On every beat, issue_mode and issue_thread carry the accepted leaf's mode and thread.
- R7: thread_done is 1 exactly on the eighth beat, and leaf_ready is 1 in the next cycle.
- R8: The following have no effect on the arrival tracking: a response with tag 3, a repeated response for a tag already seen, and any response while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| leaf_valid | input | 1 | Leaf job offered |
| leaf_ready | output | 1 | Sequencer idle and able to take a leaf |
| leaf_mode | input | 1 | 0 = triangle intersect, 1 = ray transform |
| leaf_thread | input | TID_W | Thread identifier of the four-ray group |
| leaf_base | input | ADDR_W | Base address of the leaf's three items |
| fetch_req_valid | output | 1 | Memory request pending |
| fetch_req_ready | input | 1 | Memory accepts the request |
| fetch_req_tag | output | TAG_W | Item index 0..2 |
| fetch_req_addr | output | ADDR_W | Item address |
| fetch_req_kind | output | 1 | Item kind, equal to the leaf mode |
| fetch_rsp_valid | input | 1 | Memory response present |
| fetch_rsp_tag | input | TAG_W | Tag of the returning item |
| issue_valid | output | 1 | Datapath issue beat |
| issue_ray | output | RAY_W | Ray index within the thread |
| issue_phase | output | PHASE_W | Slot of the ray (0 or 1) |
| issue_mode | output | 1 | Datapath mode select |
| issue_thread | output | TID_W | Thread identifier for the beat |
| thread_done | output | 1 | Final beat of the thread |

## Verification
Suppose the arrival mask is corrupted. If a bit is set too early, issue_valid rises before the last response, and the bench sees this within one cycle. If a bit is lost, issue never starts, and the stall shows at the first sample after the final response. A slot counter that skips or repeats a value breaks the (ray, phase) sequence on the very next beat. A controller stuck outside idle shows up the cycle after thread_done, because leaf_ready stays low. A wrong request counter shows as a wrong tag or address at the handshake where it goes wrong.

// File: rtl/leaf_seq_pkg.sv
package leaf_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ISSUE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/leaf_seq_fsm.sv
module leaf_seq_fsm
    import leaf_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic leaf_fire,
    input  logic last_req_fire,
    input  logic fetch_complete,
    input  logic last_slot,
    output logic idle,
    output logic req_phase,
    output logic collect_en,
    output logic issue_en
);
    seq_state_t state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (leaf_fire)      state_d = ST_FETCH;
            ST_FETCH: if (last_req_fire)  state_d = ST_WAIT;
            ST_WAIT:  if (fetch_complete) state_d = ST_ISSUE;
            ST_ISSUE: if (last_slot)      state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        idle       = 1'b0;
        req_phase  = 1'b0;
        collect_en = 1'b0;
        issue_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_FETCH: begin req_phase = 1'b1; collect_en = 1'b1; end
            ST_WAIT:  collect_en = 1'b1;
            ST_ISSUE: issue_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/leaf_fetch_tracker.sv
module leaf_fetch_tracker #(
    parameter int NUM_FETCH = 3,
    parameter int TAG_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             req_fire,
    input  logic             collect_en,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    output logic [TAG_W-1:0] req_idx,
    output logic             last_req,
    output logic             complete
);
    localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(NUM_FETCH - 1);

    logic [NUM_FETCH-1:0] seen_q;
    logic [NUM_FETCH-1:0] hit;
    logic [TAG_W-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              idx_q <= '0;
        else if (clear)                          idx_q <= '0;
        else if (req_fire && idx_q != LAST_IDX)  idx_q <= idx_q + 1'b1;
    end

    // One arrival flag per tag; tags with no flag match nothing.
    for (genvar i = 0; i < NUM_FETCH; i++) begin : g_slot
        assign hit[i] = collect_en && rsp_valid && (rsp_tag == TAG_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      seen_q[i] <= 1'b0;
            else if (clear)  seen_q[i] <= 1'b0;
            else if (hit[i]) seen_q[i] <= 1'b1;
        end
    end

    assign req_idx  = idx_q;
    assign last_req = (idx_q == LAST_IDX);
    assign complete = &(seen_q | hit);
endmodule

// File: rtl/leaf_issue_slots.sv
module leaf_issue_slots #(
    parameter int RAYS          = 4,
    parameter int SLOTS_PER_RAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic [$clog2(RAYS)-1:0]          ray,
    output logic [$clog2(SLOTS_PER_RAY)-1:0] phase,
    output logic last
);
    localparam int RAY_W   = $clog2(RAYS);
    localparam int PHASE_W = $clog2(SLOTS_PER_RAY);
    localparam int SLOT_W  = RAY_W + PHASE_W;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(RAYS * SLOTS_PER_RAY - 1);

    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot_q <= '0;
        else if (!en) slot_q <= '0;
        else          slot_q <= slot_q + 1'b1;
    end

    assign phase = slot_q[PHASE_W-1:0];
    assign ray   = slot_q[SLOT_W-1:PHASE_W];
    assign last  = en && (slot_q == LAST_SLOT);
endmodule

// File: rtl/geom_leaf_sequencer.sv
module geom_leaf_sequencer #(
    parameter int ADDR_W        = 32,
    parameter int TID_W         = 6,
    parameter int ITEM_BYTES    = 16,
    parameter int NUM_FETCH     = 3,
    parameter int RAYS          = 4,
    parameter int SLOTS_PER_RAY = 2,
    localparam int TAG_W        = $clog2(NUM_FETCH),
    localparam int RAY_W        = $clog2(RAYS),
    localparam int PHASE_W      = $clog2(SLOTS_PER_RAY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               leaf_valid,
    output logic               leaf_ready,
    input  logic               leaf_mode,
    input  logic [TID_W-1:0]   leaf_thread,
    input  logic [ADDR_W-1:0]  leaf_base,
    output logic               fetch_req_valid,
    input  logic               fetch_req_ready,
    output logic [TAG_W-1:0]   fetch_req_tag,
    output logic [ADDR_W-1:0]  fetch_req_addr,
    output logic               fetch_req_kind,
    input  logic               fetch_rsp_valid,
    input  logic [TAG_W-1:0]   fetch_rsp_tag,
    output logic               issue_valid,
    output logic [RAY_W-1:0]   issue_ray,
    output logic [PHASE_W-1:0] issue_phase,
    output logic               issue_mode,
    output logic [TID_W-1:0]   issue_thread,
    output logic               thread_done
);
    logic              idle, req_phase, collect_en, issue_en;
    logic              leaf_fire, req_fire, last_req, complete, last_slot;
    logic [TAG_W-1:0]  req_idx;
    logic              mode_q;
    logic [TID_W-1:0]  thread_q;
    logic [ADDR_W-1:0] base_q;

    assign leaf_fire = leaf_valid && idle;
    assign req_fire  = req_phase && fetch_req_ready;

    // Leaf context is held for the whole job.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            thread_q <= '0;
            base_q   <= '0;
        end else if (leaf_fire) begin
            mode_q   <= leaf_mode;
            thread_q <= leaf_thread;
            base_q   <= leaf_base;
        end
    end

    leaf_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .leaf_fire      (leaf_fire),
        .last_req_fire  (req_fire && last_req),
        .fetch_complete (complete),
        .last_slot      (last_slot),
        .idle           (idle),
        .req_phase      (req_phase),
        .collect_en     (collect_en),
        .issue_en       (issue_en)
    );

    leaf_fetch_tracker #(
        .NUM_FETCH (NUM_FETCH),
        .TAG_W     (TAG_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (leaf_fire),
        .req_fire   (req_fire),
        .collect_en (collect_en),
        .rsp_valid  (fetch_rsp_valid),
        .rsp_tag    (fetch_rsp_tag),
        .req_idx    (req_idx),
        .last_req   (last_req),
        .complete   (complete)
    );

    leaf_issue_slots #(
        .RAYS          (RAYS),
        .SLOTS_PER_RAY (SLOTS_PER_RAY)
    ) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (issue_en),
        .ray   (issue_ray),
        .phase (issue_phase),
        .last  (last_slot)
    );

    assign leaf_ready      = idle;
    assign fetch_req_valid = req_phase;
    assign fetch_req_tag   = req_idx;
    assign fetch_req_addr  = base_q + ADDR_W'(req_idx) * ADDR_W'(ITEM_BYTES);
    assign fetch_req_kind  = mode_q;
    assign issue_valid     = issue_en;
    assign issue_mode      = mode_q;
    assign issue_thread    = thread_q;
    assign thread_done     = last_slot;
endmodule

// File: rtl/leaf_seq_checker.sv
module leaf_seq_checker #(
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 2,
    parameter int RAY_W   = 2,
    parameter int PHASE_W = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               leaf_valid,
    input logic               leaf_ready,
    input logic               fetch_req_valid,
    input logic               fetch_req_ready,
    input logic [TAG_W-1:0]   fetch_req_tag,
    input logic [ADDR_W-1:0]  fetch_req_addr,
    input logic               fetch_rsp_valid,
    input logic [TAG_W-1:0]   fetch_rsp_tag,
    input logic               issue_valid,
    input logic [RAY_W-1:0]   issue_ray,
    input logic [PHASE_W-1:0] issue_phase,
    input logic               thread_done
);
    // Independent record of which tags came back for the current leaf.
    logic [2:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else if (leaf_valid && leaf_ready) seen_q <= '0;
        else if (fetch_rsp_valid && !leaf_ready && fetch_rsp_tag < TAG_W'(3))
            seen_q[fetch_rsp_tag[1:0]] <= 1'b1;
    end

    assert_busy_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_ready |-> (!issue_valid && !fetch_req_valid));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_valid && !fetch_req_ready) |=>
            (fetch_req_valid && $stable(fetch_req_tag) && $stable(fetch_req_addr)));

    assert_issue_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_valid) |-> (seen_q == 3'b111));

    assert_issue_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_valid) |-> (issue_ray == '0 && issue_phase == '0));

    assert_issue_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !thread_done) |=> issue_valid);

    assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        thread_done |-> (issue_valid && issue_ray == '1 && issue_phase == '1));

    assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        thread_done |=> leaf_ready);
endmodule

bind geom_leaf_sequencer leaf_seq_checker #(
    .ADDR_W  (ADDR_W),
    .TAG_W   (TAG_W),
    .RAY_W   (RAY_W),
    .PHASE_W (PHASE_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .leaf_valid      (leaf_valid),
    .leaf_ready      (leaf_ready),
    .fetch_req_valid (fetch_req_valid),
    .fetch_req_ready (fetch_req_ready),
    .fetch_req_tag   (fetch_req_tag),
    .fetch_req_addr  (fetch_req_addr),
    .fetch_rsp_valid (fetch_rsp_valid),
    .fetch_rsp_tag   (fetch_rsp_tag),
    .issue_valid     (issue_valid),
    .issue_ray       (issue_ray),
    .issue_phase     (issue_phase),
    .thread_done     (thread_done)
);

// File: tb/geom_leaf_sequencer_bench.sv
module geom_leaf_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        leaf_valid = 1'b0;
    logic        leaf_ready;
    logic        leaf_mode = 1'b0;
    logic [5:0]  leaf_thread = '0;
    logic [31:0] leaf_base = '0;
    logic        fetch_req_valid;
    logic        fetch_req_ready = 1'b0;
    logic [1:0]  fetch_req_tag;
    logic [31:0] fetch_req_addr;
    logic        fetch_req_kind;
    logic        fetch_rsp_valid = 1'b0;
    logic [1:0]  fetch_rsp_tag = '0;
    logic        issue_valid;
    logic [1:0]  issue_ray;
    logic [0:0]  issue_phase;
    logic        issue_mode;
    logic [5:0]  issue_thread;
    logic        thread_done;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic [1:0] ray;
        logic       phase;
        logic       mode;
        logic [5:0] thr;
        logic       done;
    } beat_t;
    beat_t expq[$];

    always #10 clk = ~clk;

    geom_leaf_sequencer u_geom_leaf_sequencer (
        .clk(clk), .rst_n(rst_n),
        .leaf_valid(leaf_valid), .leaf_ready(leaf_ready), .leaf_mode(leaf_mode),
        .leaf_thread(leaf_thread), .leaf_base(leaf_base),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_tag(fetch_req_tag), .fetch_req_addr(fetch_req_addr),
        .fetch_req_kind(fetch_req_kind),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_tag(fetch_rsp_tag),
        .issue_valid(issue_valid), .issue_ray(issue_ray), .issue_phase(issue_phase),
        .issue_mode(issue_mode), .issue_thread(issue_thread), .thread_done(thread_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary_and_exit();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Monitor: pops one expected beat per observed issue beat (R6, R7).
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected issue beat", 64'(issue_ray), 64'hFF);
            end else begin
                beat_t e;
                e = expq.pop_front();
                chk(issue_ray == e.ray && issue_phase == e.phase, "R6 ray/phase order",
                    {issue_ray, issue_phase}, {e.ray, e.phase});
                chk(issue_mode == e.mode && issue_thread == e.thr, "R6 mode/thread",
                    {issue_mode, issue_thread}, {e.mode, e.thr});
                chk(thread_done == e.done, "R7 done on eighth beat",
                    64'(thread_done), 64'(e.done));
            end
        end
    end

    task automatic send_rsp(input logic [1:0] tag);
        @(negedge clk);
        fetch_rsp_valid = 1'b1;
        fetch_rsp_tag   = tag;
    endtask

    task automatic run_leaf(input logic mode, input logic [5:0] thr, input logic [31:0] base,
                            input logic [1:0] o0, input logic [1:0] o1, input logic [1:0] o2,
                            input bit stall, input bit noise);
        int n;
        int cyc;
        // wait for idle, present leaf
        @(negedge clk);
        while (!leaf_ready) @(negedge clk);
        leaf_valid = 1'b1; leaf_mode = mode; leaf_thread = thr; leaf_base = base;
        @(negedge clk);
        leaf_valid = 1'b0;
        chk(leaf_ready == 1'b0, "R2 ready low after accept", 64'(leaf_ready), 64'd0);
        // request phase
        n = 0; cyc = 0;
        while (n < 3) begin
            if (cyc != 0) @(negedge clk);
            fetch_req_ready = !(stall && (cyc % 2 == 0));
            cyc++;
            if (fetch_req_ready) begin
                chk(fetch_req_valid == 1'b1, "R3 request valid", 64'(fetch_req_valid), 64'd1);
                chk(fetch_req_tag == 2'(n), "R3 request tag", 64'(fetch_req_tag), 64'(n));
                chk(fetch_req_addr == base + 32'(n * 16), "R3 request address",
                    64'(fetch_req_addr), 64'(base + 32'(n * 16)));
                chk(fetch_req_kind == mode, "R3 request kind", 64'(fetch_req_kind), 64'(mode));
                n++;
            end
        end
        @(negedge clk);
        fetch_req_ready = 1'b0;
        chk(fetch_req_valid == 1'b0, "R3 only three requests", 64'(fetch_req_valid), 64'd0);
        // responses
        send_rsp(o0);
        if (noise) begin
            send_rsp(o0);       // duplicate
            send_rsp(2'd3);     // invalid tag
            leaf_valid = 1'b1; leaf_thread = 6'h2A; leaf_mode = ~mode;
        end
        send_rsp(o1);
        @(negedge clk);
        fetch_rsp_valid = 1'b0;
        if (noise) begin
            chk(leaf_ready == 1'b0, "R2 busy ignores leaf", 64'(leaf_ready), 64'd0);
            leaf_valid = 1'b0;
        end
        @(negedge clk);
        chk(issue_valid == 1'b0, noise ? "R8 duplicate/invalid tags ignored" : "R4 no issue before third",
            64'(issue_valid), 64'd0);
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 2; p++) begin
                beat_t b;
                b.ray = 2'(r); b.phase = p[0]; b.mode = mode; b.thr = thr;
                b.done = (r == 3 && p == 1);
                expq.push_back(b);
            end
        end
        fetch_rsp_valid = 1'b1;
        fetch_rsp_tag   = o2;
        @(negedge clk);
        fetch_rsp_valid = 1'b0;
        chk(issue_valid == 1'b1, "R5 issue starts after last response", 64'(issue_valid), 64'd1);
        repeat (7) @(negedge clk);
        chk(thread_done == 1'b1, "R7 done at eighth beat", 64'(thread_done), 64'd1);
        @(negedge clk);
        chk(leaf_ready == 1'b1 && issue_valid == 1'b0, "R7 ready after done",
            {leaf_ready, issue_valid}, 64'b10);
        chk(expq.size() == 0, "R6 eight beats issued", 64'(expq.size()), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        summary_and_exit();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(leaf_ready == 1'b1 && fetch_req_valid == 1'b0 && issue_valid == 1'b0 && thread_done == 1'b0,
            "R1 reset state", {leaf_ready, fetch_req_valid, issue_valid, thread_done}, 64'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(leaf_ready == 1'b1, "R1 ready after reset", 64'(leaf_ready), 64'd1);
        // R8: responses while idle
        send_rsp(2'd0); send_rsp(2'd1); send_rsp(2'd2);
        @(negedge clk);
        fetch_rsp_valid = 1'b0;
        chk(issue_valid == 1'b0 && leaf_ready == 1'b1, "R8 idle responses ignored",
            {issue_valid, leaf_ready}, 64'b01);

        run_leaf(1'b0, 6'd5,  32'h0000_1000, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0);
        run_leaf(1'b1, 6'd9,  32'h0000_2040, 2'd2, 2'd0, 2'd1, 1'b1, 1'b1);
        run_leaf(1'b0, 6'd63, 32'hFFFF_FFF0, 2'd1, 2'd2, 2'd0, 1'b1, 1'b0);
        run_leaf(1'b1, 6'd0,  32'h0001_0008, 2'd2, 2'd1, 2'd0, 1'b0, 1'b1);
        run_leaf(1'b0, 6'd17, 32'h0000_0300, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        summary_and_exit();
    end
endmodule